// File: doc/BRIEF.md
# Signalling-Stack DMA Request Controller

This block drives two DMA request lines for a framer that holds its signalling bytes in two small stacks, one filled by the receiver and one drained by the transmitter. A stack-ready pulse from the framer core raises the request for that direction. The request then stays up until the DMA engine has serviced the stack, as seen from the bus strobes: active-low read, write, acknowledge and chip enable, plus a select line that is high when a write targets the transmit stack. Reads always service the receive stack. Stack storage and bus data are outside this block. Only the request handshake is modelled.

Two modes are available through `ext_mode`. In normal mode a request ends when the first access to its stack completes. In extended mode a request covers a three-access burst. The receive request falls when the third read begins. The transmit request falls on every acknowledge or chip-enable falling edge. It stays low while a transmit-stack write follows, and it rises again until the burst's last write completes. Every strobe is registered once in the system clock domain and compared with its registered copy to find edges. Both request outputs come from flops. A stack-ready pulse that arrives during a burst is remembered and starts a new burst afterwards.

Top module: `stack_dma_req`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after release with no stimulus, `rx_req` and `tx_req` are 0.
- R2: A 1 on `rx_ready` (or `tx_ready`) sampled at a clock edge while that request is idle with nothing pending sets the request to 1 directly after that edge.
- R3: In normal mode (`ext_mode`=0), an asserted `rx_req` goes to 0 after the edge at which `rd_n` is seen rising (0 to 1). A falling `rd_n` has no effect.
- R4: In normal mode, an asserted `tx_req` goes to 0 after the edge at which `wr_n` is seen rising while `wr_tx_sel`=1. A write ending with `wr_tx_sel`=0, and any read, leave it at 1.
- R5: In extended mode (`ext_mode`=1), `rx_req` stays 1 through the first two falling edges of `rd_n` and goes to 0 after the edge at which the third falling edge is seen. Rising edges of `rd_n` are ignored.
- R6: In extended mode, an asserted `tx_req` goes to 0 after the edge at which a falling edge of `ack_n` or `ce_n` is seen.
- R7: After an R6 drop, `tx_req` stays 0 until `wr_n` rises with `wr_tx_sel`=1. That completed write counts as a transmit access. `tx_req` returns to 1 after the first and second such writes, and stays 0 after the third, which ends the burst.
- R8: After an R6 drop, a rising `rd_n`, or a rising `wr_n` with `wr_tx_sel`=0, returns `tx_req` to 1 without counting an access.
- R9: A ready pulse seen while its request's burst is still in progress is held. When the burst ends, the request is 0 for exactly one cycle and then 1 again.
- R10: Every new burst, including one started by a held ready pulse, starts its access count at zero. In extended mode it needs three full accesses to end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_mode | input | 1 | 1 selects three-access burst handling |
| rx_ready | input | 1 | Pulse: receive stack has data for DMA |
| tx_ready | input | 1 | Pulse: transmit stack can accept DMA data |
| rd_n | input | 1 | Active-low read strobe (receive stack) |
| wr_n | input | 1 | Active-low write strobe |
| ack_n | input | 1 | Active-low DMA acknowledge |
| ce_n | input | 1 | Active-low chip enable |
| wr_tx_sel | input | 1 | 1 when the current write addresses the transmit stack |
| rx_req | output | 1 | Receive DMA request |
| tx_req | output | 1 | Transmit DMA request |

## Verification
The bench counts extended-mode reads precisely. A counter that is off by one would drop `rx_req` on the second or fourth read, and a design that still acts on rising `rd_n` in this mode would end the burst after the first read. For the transmit path the bench alternates acknowledge drops with transmit writes, a read and a deselected write. A design that counts the non-transmit cycle would end the burst early, and one that re-raises `tx_req` during the write would show it high too soon. Ready pulses are sent in the middle of bursts in both directions, and a later three-access burst checks that the count was cleared. A design that drops the held pulse would leave the request low. One that skips the one-cycle gap would never show the request falling, and one that keeps the old count would end the next burst too early.

// File: rtl/stack_dma_pkg.sv
package stack_dma_pkg;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_ARMED = 2'd1,
        CH_HOLD  = 2'd2
    } ch_state_e;

    // Edge detector slots used by the top level
    localparam int unsigned EDGE_CNT    = 5;
    localparam int unsigned E_RD_FALL   = 0;
    localparam int unsigned E_RD_RISE   = 1;
    localparam int unsigned E_WR_RISE   = 2;
    localparam int unsigned E_ACK_FALL  = 3;
    localparam int unsigned E_CE_FALL   = 4;
    // 1 = rising edge detector, 0 = falling edge detector, per slot
    localparam logic [EDGE_CNT-1:0] EDGE_RISING = 5'b00110;

endpackage

// File: rtl/strobe_edge.sv
module strobe_edge #(
    parameter bit RISING = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic hit
);

    typedef struct packed {
        logic prev;
    } edge_regs_t;

    edge_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.prev = lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.prev <= 1'b1;            // strobes idle high
        end else begin
            r_q <= r_d;
        end
    end

    generate
        if (RISING) begin : g_rise
            assign hit = lvl & ~r_q.prev;
        end else begin : g_fall
            assign hit = ~lvl & r_q.prev;
        end
    endgenerate

endmodule

// File: rtl/rx_req_chan.sv
module rx_req_chan
    import stack_dma_pkg::*;
#(
    parameter int unsigned BURST_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_mode,
    input  logic ready,
    input  logic rd_fall,
    input  logic rd_rise,
    output logic req
);

    localparam int unsigned CW = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(BURST_LEN - 1);

    typedef struct packed {
        ch_state_e     st;
        logic [CW-1:0] cnt;
        logic          pend;
        logic          req;
    } rx_regs_t;

    rx_regs_t r_d, r_q;
    logic     finish;

    always_comb begin
        r_d    = r_q;
        finish = 1'b0;
        case (r_q.st)
            CH_IDLE: begin
                if (r_q.pend || ready) begin
                    r_d.st   = CH_ARMED;
                    r_d.cnt  = '0;
                    r_d.pend = 1'b0;
                end
            end
            CH_ARMED: begin
                // extended: third access start ends burst; normal: first access end
                if (ext_mode) begin
                    finish = rd_fall && (r_q.cnt == LAST);
                    if (rd_fall && !finish) begin
                        r_d.cnt = r_q.cnt + CW'(1);
                    end
                end else begin
                    finish = rd_rise;
                end
                if (ready) begin
                    r_d.pend = 1'b1;
                end
                if (finish) begin
                    r_d.st = CH_IDLE;
                end
            end
            default: begin
                r_d.st = CH_IDLE;
            end
        endcase
        r_d.req = (r_d.st == CH_ARMED);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st   <= CH_IDLE;
            r_q.cnt  <= '0;
            r_q.pend <= 1'b0;
            r_q.req  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req = r_q.req;

endmodule

// File: rtl/tx_req_chan.sv
module tx_req_chan
    import stack_dma_pkg::*;
#(
    parameter int unsigned BURST_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_mode,
    input  logic ready,
    input  logic wr_rise,
    input  logic wr_tx_sel,
    input  logic rd_rise,
    input  logic ack_fall,
    input  logic ce_fall,
    output logic req
);

    localparam int unsigned CW = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(BURST_LEN - 1);

    typedef struct packed {
        ch_state_e     st;
        logic [CW-1:0] cnt;
        logic          pend;
        logic          req;
    } tx_regs_t;

    tx_regs_t r_d, r_q;
    logic     tx_write_done;
    logic     other_done;

    always_comb begin
        r_d           = r_q;
        tx_write_done = wr_rise && wr_tx_sel;
        other_done    = rd_rise || (wr_rise && !wr_tx_sel);
        case (r_q.st)
            CH_IDLE: begin
                if (r_q.pend || ready) begin
                    r_d.st   = CH_ARMED;
                    r_d.cnt  = '0;
                    r_d.pend = 1'b0;
                end
            end
            CH_ARMED: begin
                if (ready) begin
                    r_d.pend = 1'b1;
                end
                if (ext_mode) begin
                    if (ack_fall || ce_fall) begin
                        r_d.st = CH_HOLD;
                    end
                end else if (tx_write_done) begin
                    r_d.st = CH_IDLE;
                end
            end
            CH_HOLD: begin
                if (ready) begin
                    r_d.pend = 1'b1;
                end
                if (tx_write_done) begin
                    if (r_q.cnt == LAST) begin
                        r_d.st = CH_IDLE;
                    end else begin
                        r_d.cnt = r_q.cnt + CW'(1);
                        r_d.st  = CH_ARMED;
                    end
                end else if (other_done) begin
                    r_d.st = CH_ARMED;
                end
            end
            default: begin
                r_d.st = CH_IDLE;
            end
        endcase
        r_d.req = (r_d.st == CH_ARMED);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st   <= CH_IDLE;
            r_q.cnt  <= '0;
            r_q.pend <= 1'b0;
            r_q.req  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req = r_q.req;

endmodule

// File: rtl/stack_dma_req.sv
module stack_dma_req
    import stack_dma_pkg::*;
#(
    parameter int unsigned BURST_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_mode,
    input  logic rx_ready,
    input  logic tx_ready,
    input  logic rd_n,
    input  logic wr_n,
    input  logic ack_n,
    input  logic ce_n,
    input  logic wr_tx_sel,
    output logic rx_req,
    output logic tx_req
);

    logic [EDGE_CNT-1:0] edge_lvl;
    logic [EDGE_CNT-1:0] edge_hit;

    always_comb begin
        edge_lvl             = '1;
        edge_lvl[E_RD_FALL]  = rd_n;
        edge_lvl[E_RD_RISE]  = rd_n;
        edge_lvl[E_WR_RISE]  = wr_n;
        edge_lvl[E_ACK_FALL] = ack_n;
        edge_lvl[E_CE_FALL]  = ce_n;
    end

    generate
        for (genvar g = 0; g < EDGE_CNT; g++) begin : g_edge
            strobe_edge #(
                .RISING (EDGE_RISING[g])
            ) u_edge (
                .clk   (clk),
                .rst_n (rst_n),
                .lvl   (edge_lvl[g]),
                .hit   (edge_hit[g])
            );
        end
    endgenerate

    rx_req_chan #(
        .BURST_LEN (BURST_LEN)
    ) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_mode (ext_mode),
        .ready    (rx_ready),
        .rd_fall  (edge_hit[E_RD_FALL]),
        .rd_rise  (edge_hit[E_RD_RISE]),
        .req      (rx_req)
    );

    tx_req_chan #(
        .BURST_LEN (BURST_LEN)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_mode  (ext_mode),
        .ready     (tx_ready),
        .wr_rise   (edge_hit[E_WR_RISE]),
        .wr_tx_sel (wr_tx_sel),
        .rd_rise   (edge_hit[E_RD_RISE]),
        .ack_fall  (edge_hit[E_ACK_FALL]),
        .ce_fall   (edge_hit[E_CE_FALL]),
        .req       (tx_req)
    );

endmodule

// File: rtl/stack_dma_req_chk.sv
module stack_dma_req_chk (
    input logic clk,
    input logic rst_n,
    input logic ext_mode,
    input logic rx_ready,
    input logic tx_ready,
    input logic rd_n,
    input logic wr_n,
    input logic ack_n,
    input logic ce_n,
    input logic wr_tx_sel,
    input logic rx_req,
    input logic tx_req
);

    // An idle receive channel answers a ready pulse on the next edge
    assert_rx_raise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && !rx_req) |=> rx_req);

    assert_norm_rx_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_mode && rx_req && $rose(rd_n)) |=> !rx_req);

    assert_norm_tx_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_mode && tx_req && $rose(wr_n) && wr_tx_sel) |=> !tx_req);

    // Only a falling read strobe may end an extended receive burst
    assert_ext_rx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_mode && rx_req && !$fell(rd_n)) |=> rx_req);

    assert_ext_tx_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_mode && tx_req && ($fell(ack_n) || $fell(ce_n))) |=> !tx_req);

    // Unknown-free outputs once out of reset
    assert_known_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown({rx_req, tx_req}));

    // tx_ready is observed only through the tx request behaviour
    assert_tx_ready_raise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && !tx_req && !ext_mode && $past(!ext_mode)
         && $past(!tx_req) && !$past(tx_ready) && !$past(tx_req, 2)) |=> tx_req);

endmodule

bind stack_dma_req stack_dma_req_chk u_chk (.*);

// File: tb/stack_dma_req_bench.sv
`timescale 1ns/1ps
module stack_dma_req_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_mode = 1'b0;
    logic rx_ready = 1'b0;
    logic tx_ready = 1'b0;
    logic rd_n = 1'b1;
    logic wr_n = 1'b1;
    logic ack_n = 1'b1;
    logic ce_n = 1'b1;
    logic wr_tx_sel = 1'b0;
    logic rx_req;
    logic tx_req;

    always #2 clk = ~clk;   // 250 MHz

    stack_dma_req u_stack_dma_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_mode  (ext_mode),
        .rx_ready  (rx_ready),
        .tx_ready  (tx_ready),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .ack_n     (ack_n),
        .ce_n      (ce_n),
        .wr_tx_sel (wr_tx_sel),
        .rx_req    (rx_req),
        .tx_req    (tx_req)
    );

    // Input patterns: {rx_ready, tx_ready, rd_n, wr_n, ack_n, ce_n, wr_tx_sel}
    localparam logic [6:0] P_IDLE = 7'b0011110;
    localparam logic [6:0] P_RXR  = 7'b1011110;
    localparam logic [6:0] P_TXR  = 7'b0111110;
    localparam logic [6:0] P_RD   = 7'b0001110;
    localparam logic [6:0] P_WRT  = 7'b0010111;
    localparam logic [6:0] P_WRE  = 7'b0011111;
    localparam logic [6:0] P_WRN  = 7'b0010110;
    localparam logic [6:0] P_ACK  = 7'b0011010;
    localparam logic [6:0] P_CE   = 7'b0011100;

    typedef struct {
        logic  rx;
        logic  tx;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;

    task automatic check_now(input logic erx, input logic etx, input string tag);
        checks++;
        if (rx_req !== erx || tx_req !== etx) begin
            errors++;
            $display("FAIL %s: rx_req=%0b tx_req=%0b expected rx=%0b tx=%0b",
                     tag, rx_req, tx_req, erx, etx);
        end
    endtask

    // Driver: apply one cycle of stimulus and queue the outputs expected after the edge
    task automatic cyc(input logic [6:0] pat, input logic erx, input logic etx,
                       input string tag);
        exp_t e;
        @(negedge clk);
        {rx_ready, tx_ready, rd_n, wr_n, ack_n, ce_n, wr_tx_sel} = pat;
        e.rx  = erx;
        e.tx  = etx;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compare after each edge, away from the edge itself
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check_now(e.rx, e.tx, e.tag);
        end
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: rx_req=%0b tx_req=%0b expected run to finish",
                     rx_req, tx_req);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_now(1'b0, 1'b0, "R1 in reset");
        rst_n = 1'b1;
        cyc(P_IDLE, 0, 0, "R1 after release");

        // Normal receive
        ext_mode = 1'b0;
        cyc(P_RXR,  1, 0, "R2 rx raise");
        cyc(P_IDLE, 1, 0, "R2 rx held");
        cyc(P_RD,   1, 0, "R3 fall ignored");
        cyc(P_RD,   1, 0, "R3 read low");
        cyc(P_IDLE, 0, 0, "R3 drop on read end");
        cyc(P_IDLE, 0, 0, "R3 stays low");

        // Normal transmit
        cyc(P_TXR,  0, 1, "R2 tx raise");
        cyc(P_WRN,  0, 1, "R4 other write start");
        cyc(P_IDLE, 0, 1, "R4 deselected write end ignored");
        cyc(P_RD,   0, 1, "R4 read start");
        cyc(P_IDLE, 0, 1, "R4 read end ignored");
        cyc(P_WRT,  0, 1, "R4 tx write start");
        cyc(P_WRE,  0, 0, "R4 drop on tx write end");
        cyc(P_IDLE, 0, 0, "R4 stays low");

        // Extended receive
        ext_mode = 1'b1;
        cyc(P_RXR,  1, 0, "R2 ext rx raise");
        cyc(P_RD,   1, 0, "R5 first read");
        cyc(P_IDLE, 1, 0, "R5 rise ignored");
        cyc(P_RD,   1, 0, "R5 second read");
        cyc(P_IDLE, 1, 0, "R5 between");
        cyc(P_RD,   0, 0, "R5 third read start");
        cyc(P_IDLE, 0, 0, "R5 stays low");

        // Extended transmit
        cyc(P_TXR,  0, 1, "R2 ext tx raise");
        cyc(P_ACK,  0, 0, "R6 ack drop");
        cyc(P_WRT,  0, 0, "R7 low during write");
        cyc(P_WRE,  0, 1, "R7 back after write 1");
        cyc(P_IDLE, 0, 1, "R7 held");
        cyc(P_CE,   0, 0, "R6 ce drop");
        cyc(P_IDLE, 0, 0, "R8 hold low");
        cyc(P_RD,   0, 0, "R8 read start");
        cyc(P_IDLE, 0, 1, "R8 back after read");
        cyc(P_ACK,  0, 0, "R6 ack drop 2");
        cyc(P_WRN,  0, 0, "R8 other write start");
        cyc(P_IDLE, 0, 1, "R8 back after deselected write");
        cyc(P_ACK,  0, 0, "R6 ack drop 3");
        cyc(P_WRT,  0, 0, "R7 write 2 low");
        cyc(P_WRE,  0, 1, "R7 back after write 2");
        cyc(P_ACK,  0, 0, "R6 ack drop 4");
        cyc(P_WRT,  0, 0, "R7 write 3 low");
        cyc(P_WRE,  0, 0, "R7 burst ends on write 3");
        cyc(P_IDLE, 0, 0, "R7 stays low");

        // Pending receive ready in extended mode
        cyc(P_RXR,  1, 0, "R9 rx raise");
        cyc(P_RD,   1, 0, "R9 read 1");
        cyc(P_RXR,  1, 0, "R9 ready during burst");
        cyc(P_RD,   1, 0, "R9 read 2");
        cyc(P_IDLE, 1, 0, "R9 between");
        cyc(P_RD,   0, 0, "R9 burst end gap");
        cyc(P_IDLE, 1, 0, "R9 re-raise");
        cyc(P_RD,   1, 0, "R10 read 1");
        cyc(P_IDLE, 1, 0, "R10 between");
        cyc(P_RD,   1, 0, "R10 read 2 still high");
        cyc(P_IDLE, 1, 0, "R10 between 2");
        cyc(P_RD,   0, 0, "R10 read 3 ends");
        cyc(P_IDLE, 0, 0, "R10 stays low");

        // Pending transmit ready in normal mode
        ext_mode = 1'b0;
        cyc(P_TXR,  0, 1, "R9 tx raise");
        cyc(P_TXR,  0, 1, "R9 tx ready during burst");
        cyc(P_WRT,  0, 1, "R9 tx write start");
        cyc(P_WRE,  0, 0, "R9 tx gap");
        cyc(P_IDLE, 0, 1, "R9 tx re-raise");
        cyc(P_WRT,  0, 1, "R10 tx write start");
        cyc(P_WRE,  0, 0, "R10 tx ends");
        cyc(P_IDLE, 0, 0, "R10 tx stays low");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule